// File: doc/BRIEF.md
# Sync Detection Status Register

This block watches three synchronisation inputs (a vertical sync line, a horizontal or composite sync line, and a vertical sync stream extracted from the composite signal), an over-voltage event input and two lock indicators. From them it builds an 8-bit read-only status byte that a host serial-bus slave returns on a read. Each sync input passes through a synchronizer. Any rising edge of the synchronized line is taken as a pulse, whatever the line's polarity, and sets a sticky detection flag. The host clears these flags with a one-cycle detection-clear command. After such a clear, the host must wait at least one full sync period before it trusts a flag that still reads 0.

Polarity is judged digitally. Over each window of 2^WIN_LOG2 clocks, the block counts how many cycles the synchronized vertical and horizontal lines were high. A line that was high for less than half the window carries positive-going pulses. The over-voltage alarm is sticky. It survives the detection clear and clears only through its own command or the power-on reset. While it is set, the horizontal drive output is held low.

Top module: `sync_status_reg`

## Requirements
- R1: Status byte bit positions are: bit 0 vertical sync detected, bit 1 horizontal/composite sync detected, bit 2 extracted vertical sync detected, bit 3 vertical polarity, bit 4 horizontal polarity, bit 5 over-voltage alarm, bit 6 vertical amplitude not locked, bit 7 horizontal PLL not locked. After reset, bits 0 to 5 read 0.
- R2: A rising edge on a sync input sets its detection bit two clocks after the clock edge that first samples the new high level. The bit stays 1 after the pulses stop.
- R3: Detection bits 0 to 2 return to 0 only on a clock edge where `det_clear` is 1. `det_clear` leaves bit 5 unchanged.
- R4: When `det_clear` falls on the same edge as a new detection event, the detection bit reads 1 afterwards.
- R5: At the end of each window of 2^WIN_LOG2 clocks after reset, a polarity bit (bit 3 vertical, bit 4 horizontal) becomes 1 if the synchronized line was high for at least half the window, and 0 otherwise. Between window ends it holds its value, and it reads 0 after reset.
- R6: A synchronized high on `xv_event_in` sets bit 5. Only `alarm_clear` or reset clears it, and a new event on the same edge as `alarm_clear` leaves it at 1.
- R7: `hdrive_out` equals `hdrive_in` while bit 5 is 0, and is 0 while bit 5 is 1.
- R8: Bit 6 is the inverse of `vamp_locked_in` and bit 7 the inverse of `hpll_locked_in`, each delayed by the synchronizer (two clocks by default).

Each 1-bit port listed below has its own port-list entry in the source, in the order given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| vsync_in | input | 1 | Vertical sync line, asynchronous |
| hsync_in | input | 1 | Horizontal or composite sync line, asynchronous |
| vextr_in | input | 1 | Vertical sync extracted from composite, asynchronous |
| xv_event_in | input | 1 | Over-voltage comparator output, high on excess |
| vamp_locked_in | input | 1 | 1 while vertical amplitude loop is locked |
| hpll_locked_in | input | 1 | 1 while horizontal PLL is locked |
| det_clear | input | 1 | One-cycle command clearing detection bits 0 to 2 |
| alarm_clear | input | 1 | One-cycle command clearing the over-voltage alarm |
| hdrive_in | input | 1 | Horizontal drive from the deflection stage |
| hdrive_out | output | 1 | Horizontal drive after alarm gating |
| status_byte | output | 8 | Assembled status byte |

## Verification
Two pairs of functions can act on the same clock edge. In the first, a detection clear meets a new sync rising edge. In the second, an alarm clear meets a new over-voltage event. The bench provokes each pair by driving the input level and then raising the clear command exactly two falling edges later, so both act on the flag-update edge. A reference model, advanced on every clock, predicts that the flag stays at 1, and explicit checks confirm it. The polarity boundary, exactly half the window high, is provoked with a line that toggles every clock, and it must read 1.

// File: rtl/sync_stat_pkg.sv
package sync_stat_pkg;

   // input lane indices inside the raw input vector
   localparam int unsigned LANE_V    = 0;
   localparam int unsigned LANE_H    = 1;
   localparam int unsigned LANE_X    = 2;
   localparam int unsigned LANE_XV   = 3;
   localparam int unsigned LANE_VLK  = 4;
   localparam int unsigned LANE_HLK  = 5;
   localparam int unsigned NUM_LANES = 6;

   // lanes that feed sticky detection flags / polarity meters
   localparam int unsigned NUM_DET = 3;
   localparam int unsigned NUM_POL = 2;

   // status byte, MSB first (bit 7 .. bit 0)
   typedef struct packed {
      logic hpll_unlocked;
      logic vamp_unlocked;
      logic xv_alarm;
      logic h_negative;
      logic v_negative;
      logic vx_seen;
      logic h_seen;
      logic v_seen;
   } status_t;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ssr_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];

endmodule

// File: rtl/ssr_rise.sv
module ssr_rise #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);

   logic [WIDTH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ssr_sticky.sv
module ssr_sticky #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set,
   input  logic             clr,
   output logic [WIDTH-1:0] q
);

   // a set on the same edge as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= set | (q & ~{WIDTH{clr}});
   end

endmodule

// File: rtl/ssr_polarity.sv
module ssr_polarity #(
   parameter int WIN_LOG2 = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic negative
);

   generate
      if (WIN_LOG2 < 2 || WIN_LOG2 > 24) begin : g_bad_win
         $error("ssr_polarity: WIN_LOG2 must lie in 2..24");
      end
   endgenerate

   localparam int CW = WIN_LOG2 + 1;
   localparam logic [CW-1:0] HALF_CNT = {1'b0, 1'b1, {(WIN_LOG2-1){1'b0}}};

   logic [WIN_LOG2-1:0] tick;
   logic [CW-1:0]       high_cnt;
   logic [CW-1:0]       high_next;
   logic                win_end;

   assign win_end   = &tick;
   assign high_next = high_cnt + {{WIN_LOG2{1'b0}}, lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick     <= '0;
         high_cnt <= '0;
         negative <= 1'b0;
      end else begin
         tick <= tick + 1'b1;
         if (win_end) begin
            negative <= (high_next >= HALF_CNT);
            high_cnt <= '0;
         end else begin
            high_cnt <= high_next;
         end
      end
   end

endmodule

// File: rtl/sync_status_reg.sv
module sync_status_reg
   import sync_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIN_LOG2    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vsync_in,
   input  logic       hsync_in,
   input  logic       vextr_in,
   input  logic       xv_event_in,
   input  logic       vamp_locked_in,
   input  logic       hpll_locked_in,
   input  logic       det_clear,
   input  logic       alarm_clear,
   input  logic       hdrive_in,
   output logic       hdrive_out,
   output logic [7:0] status_byte
);

   logic [NUM_LANES-1:0] raw;
   logic [NUM_LANES-1:0] lvl;
   logic [NUM_DET-1:0]   det_rise;
   logic [NUM_DET-1:0]   det_flag;
   logic [NUM_POL-1:0]   pol_neg;
   logic                 alarm;
   status_t              st;

   always_comb begin
      raw           = '0;
      raw[LANE_V]   = vsync_in;
      raw[LANE_H]   = hsync_in;
      raw[LANE_X]   = vextr_in;
      raw[LANE_XV]  = xv_event_in;
      raw[LANE_VLK] = vamp_locked_in;
      raw[LANE_HLK] = hpll_locked_in;
   end

   ssr_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (lvl)
   );

   ssr_rise #(.WIDTH(NUM_DET)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl[NUM_DET-1:0]),
      .rise  (det_rise)
   );

   ssr_sticky #(.WIDTH(NUM_DET)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (det_rise),
      .clr   (det_clear),
      .q     (det_flag)
   );

   ssr_sticky #(.WIDTH(1)) u_alarm (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (lvl[LANE_XV]),
      .clr   (alarm_clear),
      .q     (alarm)
   );

   generate
      for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
         ssr_polarity #(.WIN_LOG2(WIN_LOG2)) u_pol (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[p]),
            .negative (pol_neg[p])
         );
      end
   endgenerate

   always_comb begin
      st.v_seen        = det_flag[LANE_V];
      st.h_seen        = det_flag[LANE_H];
      st.vx_seen       = det_flag[LANE_X];
      st.v_negative    = pol_neg[LANE_V];
      st.h_negative    = pol_neg[LANE_H];
      st.xv_alarm      = alarm;
      st.vamp_unlocked = ~lvl[LANE_VLK];
      st.hpll_unlocked = ~lvl[LANE_HLK];
   end

   assign status_byte = st;
   assign hdrive_out  = hdrive_in & ~alarm;

endmodule

// File: rtl/sync_status_chk.sv
module sync_status_chk #(
   parameter int WIN_LOG2 = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       det_clear,
   input logic       alarm_clear,
   input logic       hdrive_out,
   input logic [7:0] status_byte
);

   // cycles since reset, modulo the polarity window
   logic [WIN_LOG2-1:0] phase;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + 1'b1;
   end

   a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[0] && !det_clear) |=> status_byte[0]);

   a_r3_clear_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_byte[1]) |-> $past(det_clear));

   a_r5_pol_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_byte[4:3]) |-> (phase == '0));

   a_r6_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[5] && !alarm_clear) |=> status_byte[5]);

   a_r6_alarm_clear_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_byte[5]) |-> $past(alarm_clear));

   a_r7_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[5] |-> !hdrive_out);

endmodule

bind sync_status_reg sync_status_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .det_clear   (det_clear),
   .alarm_clear (alarm_clear),
   .hdrive_out  (hdrive_out),
   .status_byte (status_byte)
);

// File: tb/sim_sync_status_reg.sv
`timescale 1ns/1ps
module sim_sync_status_reg;

   localparam int WL  = 8;
   localparam int WIN = 1 << WL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_in = 0, hsync_in = 0, vextr_in = 0, xv_event_in = 0;
   logic vamp_locked_in = 1, hpll_locked_in = 1;
   logic det_clear = 0, alarm_clear = 0, hdrive_in = 1;
   logic hdrive_out;
   logic [7:0] status_byte;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   sync_status_reg #(.SYNC_STAGES(2), .WIN_LOG2(WL)) u0 (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
      .vextr_in(vextr_in), .xv_event_in(xv_event_in),
      .vamp_locked_in(vamp_locked_in), .hpll_locked_in(hpll_locked_in),
      .det_clear(det_clear), .alarm_clear(alarm_clear),
      .hdrive_in(hdrive_in), .hdrive_out(hdrive_out), .status_byte(status_byte)
   );

   // ---------------- reference model ----------------
   logic [5:0] hist [$];      // sampled inputs, index 0 = newest
   logic [2:0] m_det;
   logic       m_alarm;
   logic [1:0] m_pol;
   int         m_hi [2];
   int         m_cyc;
   logic [7:0] m_byte;

   always @(posedge clk) begin
      logic [5:0] cur;
      cur = {hpll_locked_in, vamp_locked_in, xv_event_in, vextr_in, hsync_in, vsync_in};
      if (!rst_n) begin
         hist = '{6'd0, 6'd0, 6'd0};
         m_det = '0; m_alarm = 0; m_pol = '0;
         m_hi[0] = 0; m_hi[1] = 0; m_cyc = 0;
      end else begin
         for (int c = 0; c < 3; c++)
            m_det[c] = (hist[1][c] && !hist[2][c]) || (m_det[c] && !det_clear);
         m_alarm = hist[1][3] || (m_alarm && !alarm_clear);
         for (int c = 0; c < 2; c++) m_hi[c] += int'(hist[1][c]);
         m_cyc++;
         if (m_cyc == WIN) begin
            for (int c = 0; c < 2; c++) begin
               m_pol[c] = (m_hi[c] >= WIN / 2);
               m_hi[c] = 0;
            end
            m_cyc = 0;
         end
         hist.push_front(cur);
         void'(hist.pop_back());
      end
      m_byte = {~hist[1][5], ~hist[1][4], m_alarm, m_pol[1], m_pol[0], m_det};
   end

   function automatic string req_of(input logic [7:0] diff);
      if (diff[2:0] != 0) return "R2";
      if (diff[4:3] != 0) return "R5";
      if (diff[5])        return "R6";
      return "R8";
   endfunction

   // per-clock comparison, well away from the rising edge
   always @(negedge clk) begin
      #5;
      if (rst_n && !finished) begin
         n_chk++;
         if (status_byte !== m_byte) begin
            n_fail++;
            $display("FAIL %s status_byte actual=%h expected=%h", req_of(status_byte ^ m_byte),
                     status_byte, m_byte);
         end
         n_chk++;
         if (hdrive_out !== (hdrive_in & ~m_alarm)) begin
            n_fail++;
            $display("FAIL R7 hdrive_out actual=%b expected=%b", hdrive_out, hdrive_in & ~m_alarm);
         end
      end
   end

   // ---------------- explicit checks ----------------
   task automatic settle();
      @(negedge clk); #5;
   endtask

   task automatic chk_bits(input string req, input logic [7:0] mask, input logic [7:0] exp);
      n_chk++;
      if ((status_byte & mask) !== (exp & mask)) begin
         n_fail++;
         $display("FAIL %s masked status actual=%h expected=%h", req, status_byte & mask, exp & mask);
      end
   endtask

   task automatic chk_drive(input string req, input logic exp);
      n_chk++;
      if (hdrive_out !== exp) begin
         n_fail++;
         $display("FAIL %s hdrive_out actual=%b expected=%b", req, hdrive_out, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(3); settle();
      chk_bits("R1 reset value", 8'hFF, 8'h00);
      chk_drive("R7 no alarm", 1'b1);

      // pulse trains: vertical positive (25% high), horizontal negative (75% high)
      for (int c = 0; c < 800; c++) begin
         @(negedge clk);
         vsync_in = ((c % 40) < 10);
         hsync_in = ((c % 32) >= 8);
         vextr_in = ((c % 100) < 3);
      end
      settle();
      chk_bits("R2 flags set", 8'h07, 8'h07);
      chk_bits("R5 polarity v pos h neg", 8'h18, 8'h10);
      chk_bits("R1 bit map", 8'hFF, 8'h17);

      // pulses stop
      @(negedge clk);
      vsync_in = 0; hsync_in = 0; vextr_in = 0;
      idle(600); settle();
      chk_bits("R2 flags stay", 8'h07, 8'h07);
      chk_bits("R5 quiet line positive", 8'h18, 8'h00);

      // over-voltage event
      @(negedge clk); xv_event_in = 1;
      @(negedge clk); xv_event_in = 0;
      idle(3); settle();
      chk_bits("R6 alarm set", 8'h20, 8'h20);
      chk_drive("R7 drive gated", 1'b0);

      // detection clear leaves alarm
      @(negedge clk); det_clear = 1;
      @(negedge clk); det_clear = 0;
      settle();
      chk_bits("R3 det cleared", 8'h07, 8'h00);
      chk_bits("R3 alarm kept", 8'h20, 8'h20);

      // R4: clear on the same edge as a new vertical detection
      @(negedge clk); vsync_in = 1;
      @(negedge clk);
      @(negedge clk); det_clear = 1;
      @(negedge clk); det_clear = 0;
      settle();
      chk_bits("R4 set beats clear", 8'h01, 8'h01);
      @(negedge clk); vsync_in = 0;

      // R6: alarm clear on the same edge as a new event
      @(negedge clk); xv_event_in = 1;
      @(negedge clk); xv_event_in = 0;
      @(negedge clk); alarm_clear = 1;
      @(negedge clk); alarm_clear = 0;
      settle();
      chk_bits("R6 event beats clear", 8'h20, 8'h20);
      idle(3);
      @(negedge clk); alarm_clear = 1;
      @(negedge clk); alarm_clear = 0;
      settle();
      chk_bits("R6 alarm cleared", 8'h20, 8'h00);
      chk_bits("R6 alarm clear leaves det", 8'h01, 8'h01);
      chk_drive("R7 drive released", 1'b1);
      @(negedge clk); hdrive_in = 0;
      settle();
      chk_drive("R7 drive follows", 1'b0);
      @(negedge clk); hdrive_in = 1;

      // lock pass-through
      @(negedge clk); vamp_locked_in = 0;
      idle(2); settle();
      chk_bits("R8 vertical unlocked", 8'hC0, 8'h40);
      @(negedge clk); hpll_locked_in = 0; vamp_locked_in = 1;
      idle(2); settle();
      chk_bits("R8 horizontal unlocked", 8'hC0, 8'h80);
      @(negedge clk); hpll_locked_in = 1;

      // exactly half high: toggling line
      for (int c = 0; c < 700; c++) begin
         @(negedge clk);
         vsync_in = c[0];
      end
      settle();
      chk_bits("R5 half high reads negative", 8'h08, 8'h08);
      @(negedge clk); vsync_in = 0;
      idle(5);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

endmodule